// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Controller

This block produces the active-low system reset for a processor subsystem. Three causes drive it low: power being applied, an external comparator reporting that the supply is out of range, and a watchdog that the processor failed to service in time. When a cause goes away, the reset is held for a fixed hold time before it is released. The same hold is applied after a watchdog expiry, so every expiry gives one reset pulse of fixed length.

The processor services the watchdog by driving a falling edge on the strobe input. Only a high-to-low change counts. A strobe left high or left low lets the watchdog run out. A 2-bit setting chooses one of three periods or turns the watchdog off. Every duration is a whole number of ticks from a prescaler. The prescaler restarts whenever a timing interval starts, so each duration is exact to the clock cycle.

The supply-good flag clears the block asynchronously, so reset drops at once with no clock edge needed. The release back into the clock domain goes through a two-stage synchroniser.

Top module: `wdog_supervisor`

## Requirements
- R1: The reset output `rstN` is active low and is 0 while `supplyOk` is 0 from power-up.
- R2: After `supplyOk` goes to 1, `rstN` rises at the (HOLD_TICKS*TICK_DIV+2)-th rising clock edge, counting the first edge that samples `supplyOk` high as edge 1. Any return of `supplyOk` to 0 during the hold restarts this count from the next rise.
- R3: `supplyOk` going to 0 drives `rstN` to 0 at once, without waiting for a clock edge.
- R4: The period is chosen by `wdCfg`: code 00 gives SLOW_TICKS, code 01 gives MID_TICKS and code 10 gives FAST_TICKS prescaler ticks. With the strobe held steady (high or low), `rstN` falls exactly period*TICK_DIV clock edges after the edge that released it.
- R5: After a watchdog expiry, `rstN` stays 0 for exactly HOLD_TICKS*TICK_DIV clock edges and then rises.
- R6: A high-to-low change on `wdStrobe` restarts the watchdog. When no further fall follows, `rstN` falls at the (period*TICK_DIV+3)-th edge after the fall, counting the first edge that samples the strobe low as edge 1.
- R7: A low-to-high change on `wdStrobe` has no effect on the watchdog.
- R8: Code 11 turns the watchdog off. `rstN` stays 1 for as long as that code is held. After a change to an active code, a full period is timed from that change.
- R9: While reset is held, the watchdog count stays at zero. Strobe falls during the hold do not shorten the first period after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| supplyOk | input | 1 | Supply-good flag from the external comparator; 0 clears the block asynchronously |
| wdStrobe | input | 1 | Watchdog service strobe, asynchronous; a falling edge restarts the watchdog |
| wdCfg | input | 2 | Watchdog period select: 00 slow, 01 mid, 10 fast, 11 off |
| rstN | output | 1 | System reset, active low |

## Verification
The assertions assume that `wdCfg` changes only as a quasi-static setting. They also assume that each level of `wdStrobe` lasts at least one clock cycle, so the synchroniser sees every edge, and that `supplyOk` is the only source of clearing. The stimulus changes every input just after a falling clock edge. It holds each strobe level for at least two cycles. It spaces random service falls closer together than the selected period, and it keeps strobe falls out of the last cycles before a release, so that each expected edge count stays exact.

// File: rtl/wdog_supervisor_pkg.sv
package wdog_supervisor_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } sup_state_e;

  typedef struct packed {
    logic clear;  // restart prescaler and tick counter
    logic count;  // let the prescaler advance
  } tmr_cmd_t;

endpackage

// File: rtl/wdog_sup_datapath.sv
module wdog_sup_datapath
  import wdog_supervisor_pkg::*;
#(
  parameter int TICK_DIV = 50000,
  parameter int TMR_W    = 11
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic             wdStrobe,
  input  tmr_cmd_t         cmd,
  output logic             tick,
  output logic [TMR_W-1:0] tmrCnt,
  output logic             kick
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [2:0]       stbSync;

  assign tick = cmd.count && (divCnt == DIV_LAST);
  assign kick = stbSync[2] && !stbSync[1];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      divCnt <= '0;
      tmrCnt <= '0;
    end else if (cmd.clear) begin
      divCnt <= '0;
      tmrCnt <= '0;
    end else if (cmd.count) begin
      divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + DIV_W'(1);
      if (tick) tmrCnt <= tmrCnt + TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) stbSync <= '0;
    else        stbSync <= {stbSync[1:0], wdStrobe};
  end

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!arstN)
    (tmrCnt != $past(tmrCnt)) |-> (tmrCnt == '0 || tmrCnt == $past(tmrCnt) + TMR_W'(1)));

endmodule

// File: rtl/wdog_sup_control.sv
module wdog_sup_control
  import wdog_supervisor_pkg::*;
#(
  parameter int HOLD_TICKS = 200,
  parameter int SLOW_TICKS = 1400,
  parameter int MID_TICKS  = 600,
  parameter int FAST_TICKS = 200,
  parameter int TMR_W      = 11
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [1:0]       wdCfg,
  input  logic             tick,
  input  logic [TMR_W-1:0] tmrCnt,
  input  logic             kick,
  output tmr_cmd_t         cmd,
  output logic             rstN
);

  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD_TICKS - 1);

  sup_state_e       state, nextState;
  logic [1:0]       okSync;
  logic             okQ;
  logic             wdOff;
  logic [TMR_W-1:0] wdLast;

  assign okQ   = okSync[1];
  assign wdOff = (wdCfg == 2'b11);

  always_comb begin
    case (wdCfg)
      2'b01:   wdLast = TMR_W'(MID_TICKS - 1);
      2'b10:   wdLast = TMR_W'(FAST_TICKS - 1);
      default: wdLast = TMR_W'(SLOW_TICKS - 1);
    endcase
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    case (state)
      ST_HOLD: begin
        cmd.count = okQ;
        cmd.clear = !okQ;
        if (tick && tmrCnt >= HOLD_LAST) begin
          nextState = ST_RUN;
          cmd.clear = 1'b1;
        end
      end
      default: begin
        cmd.count = !wdOff;
        if (wdOff || kick) begin
          cmd.clear = 1'b1;
        end else if (tick && tmrCnt >= wdLast) begin
          nextState = ST_HOLD;
          cmd.clear = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      okSync <= '0;
      state  <= ST_HOLD;
      rstN   <= 1'b0;
    end else begin
      okSync <= {okSync[0], 1'b1};
      state  <= nextState;
      rstN   <= (nextState == ST_RUN);
    end
  end

  // R3
  lowsupply_chk: assert property (@(posedge clk) !arstN |-> !rstN);

  // R8
  off_no_expire_chk: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstN) |-> ($past(wdCfg) != 2'b11));

  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(rstN) |-> $past(tick));

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!arstN)
    $fell(rstN) |-> (tmrCnt == '0));

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_supervisor_pkg::*;
#(
  parameter int TICK_DIV   = 50000,
  parameter int HOLD_TICKS = 200,
  parameter int SLOW_TICKS = 1400,
  parameter int MID_TICKS  = 600,
  parameter int FAST_TICKS = 200
) (
  input  logic       clk,
  input  logic       supplyOk,
  input  logic       wdStrobe,
  input  logic [1:0] wdCfg,
  output logic       rstN
);

  localparam int MAX_A = (SLOW_TICKS > MID_TICKS) ? SLOW_TICKS : MID_TICKS;
  localparam int MAX_B = (FAST_TICKS > HOLD_TICKS) ? FAST_TICKS : HOLD_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_T + 1);

  tmr_cmd_t         cmd;
  logic             tick;
  logic             kick;
  logic [TMR_W-1:0] tmrCnt;

  wdog_sup_datapath #(
    .TICK_DIV(TICK_DIV),
    .TMR_W   (TMR_W)
  ) u_dp (
    .clk     (clk),
    .arstN   (supplyOk),
    .wdStrobe(wdStrobe),
    .cmd     (cmd),
    .tick    (tick),
    .tmrCnt  (tmrCnt),
    .kick    (kick)
  );

  wdog_sup_control #(
    .HOLD_TICKS(HOLD_TICKS),
    .SLOW_TICKS(SLOW_TICKS),
    .MID_TICKS (MID_TICKS),
    .FAST_TICKS(FAST_TICKS),
    .TMR_W     (TMR_W)
  ) u_ctl (
    .clk   (clk),
    .arstN (supplyOk),
    .wdCfg (wdCfg),
    .tick  (tick),
    .tmrCnt(tmrCnt),
    .kick  (kick),
    .cmd   (cmd),
    .rstN  (rstN)
  );

endmodule

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;

  localparam int DIV  = 4;
  localparam int HOLD = 8;
  localparam int SLOW = 56;
  localparam int MID  = 24;
  localparam int FAST = 8;
  localparam int HOLD_CYC = HOLD * DIV;

  logic       clk = 1'b0;
  logic       supplyOk = 1'b0;
  logic       wdStrobe = 1'b1;
  logic [1:0] wdCfg = 2'b00;
  logic       rstN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  wdog_supervisor #(
    .TICK_DIV(DIV), .HOLD_TICKS(HOLD), .SLOW_TICKS(SLOW),
    .MID_TICKS(MID), .FAST_TICKS(FAST)
  ) u_dut (
    .clk(clk), .supplyOk(supplyOk), .wdStrobe(wdStrobe), .wdCfg(wdCfg), .rstN(rstN)
  );

  function automatic int periodCyc(input logic [1:0] c);
    case (c)
      2'b00:   return SLOW * DIV;
      2'b01:   return MID * DIV;
      default: return FAST * DIV;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cntUntil(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (rstN !== lvl && n < 2000);
  endtask

  task automatic finish();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish();
    end
  end

  initial begin
    int n;
    bit highOk;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(rstN == 1'b0, "R1", rstN, 0);

    supplyOk = 1'b1;
    cntUntil(1'b1, n);
    check(n == HOLD_CYC + 2, "R2", n, HOLD_CYC + 2);

    cntUntil(1'b0, n);
    check(n == periodCyc(2'b00), "R4", n, periodCyc(2'b00));
    cntUntil(1'b1, n);
    check(n == HOLD_CYC, "R5", n, HOLD_CYC);

    // R3 immediate drop, R2 restart on glitch
    repeat (5) @(negedge clk);
    supplyOk = 1'b0;
    #1;
    check(rstN == 1'b0, "R3", rstN, 0);
    @(negedge clk);
    supplyOk = 1'b1;
    repeat (10) @(negedge clk);
    supplyOk = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    cntUntil(1'b1, n);
    check(n == HOLD_CYC + 2, "R2", n, HOLD_CYC + 2);

    for (int c = 0; c < 3; c++) begin
      wdCfg = 2'(c);
      cntUntil(1'b0, n);
      check(n == periodCyc(2'(c)), "R4", n, periodCyc(2'(c)));
      cntUntil(1'b1, n);
      check(n == HOLD_CYC, "R5", n, HOLD_CYC);
    end

    // R6: one fall then held low
    wdCfg = 2'b01;
    repeat (20) @(negedge clk);
    wdStrobe = 1'b0;
    cntUntil(1'b0, n);
    check(n == periodCyc(2'b01) + 3, "R6", n, periodCyc(2'b01) + 3);
    cntUntil(1'b1, n);
    check(n == HOLD_CYC, "R5", n, HOLD_CYC);

    // R7: a rise does not restart
    repeat (30) @(negedge clk);
    wdStrobe = 1'b1;
    cntUntil(1'b0, n);
    check(n == periodCyc(2'b01) - 30, "R7", n, periodCyc(2'b01) - 30);

    // R9: falls during hold are ignored
    repeat (5) @(negedge clk);
    wdStrobe = 1'b0;
    repeat (5) @(negedge clk);
    wdStrobe = 1'b1;
    repeat (3) @(negedge clk);
    wdStrobe = 1'b0;
    cntUntil(1'b1, n);
    check(n == HOLD_CYC - 13, "R9", n, HOLD_CYC - 13);
    cntUntil(1'b0, n);
    check(n == periodCyc(2'b01), "R9", n, periodCyc(2'b01));
    cntUntil(1'b1, n);

    // R8: watchdog off, then a fresh period
    wdCfg = 2'b11;
    highOk = 1'b1;
    repeat (3 * SLOW * DIV) begin
      @(negedge clk);
      if (rstN !== 1'b1) highOk = 1'b0;
    end
    check(highOk, "R8", highOk, 1);
    wdCfg = 2'b10;
    cntUntil(1'b0, n);
    check(n == periodCyc(2'b10), "R8", n, periodCyc(2'b10));
    wdStrobe = 1'b1;
    cntUntil(1'b1, n);

    // R6 random service patterns
    for (int it = 0; it < 12; it++) begin
      int lim;
      int kicks;
      logic [1:0] c;
      c = 2'($urandom % 3);
      wdCfg = c;
      lim = periodCyc(c);
      kicks = 1 + int'($urandom % 5);
      highOk = 1'b1;
      for (int k = 0; k < kicks; k++) begin
        int gap;
        gap = 4 + int'($urandom % (lim - 8));
        repeat (gap - 2) begin
          @(negedge clk);
          if (rstN !== 1'b1) highOk = 1'b0;
        end
        wdStrobe = 1'b0;
        repeat (2) begin
          @(negedge clk);
          if (rstN !== 1'b1) highOk = 1'b0;
        end
        wdStrobe = 1'b1;
      end
      check(highOk, "R6", highOk, 1);
      cntUntil(1'b0, n);
      check(n == lim + 1, "R6", n, lim + 1);
      cntUntil(1'b1, n);
      check(n == HOLD_CYC, "R5", n, HOLD_CYC);
    end

    finish();
  end

endmodule